// File: doc/BRIEF.md
# Strip Charge Peak and Centroid Finder

This block examines one slice of sixteen strip charges per clock. It picks the strip with the largest charge, forwards that charge together with the charges of the strips immediately below and above it, and derives the charge-weighted centre of mass of those three strips. A restoring divider turns the weighted sum into a strip coordinate with fractional bits. The coordinate is then scaled by the strip pitch into a position in micrometres.

The datapath is fully pipelined. A new slice may be accepted on every cycle. The selected address and charges travel beside the divider, so every output belongs to the same slice and appears after a fixed number of cycles.

Top module: `strip_centroid_top`

## Requirements
- R1: `out_max_addr` is the index (0..15) of the strip whose 8-bit charge in `in_q[8*i +: 8]` is largest, and `out_q_max` is that charge; when several strips share the largest charge, the lowest index is reported.
- R2: `out_q_lo` and `out_q_hi` are the charges at index `out_max_addr-1` and `out_max_addr+1`; at index 0 `out_q_lo` is 0 and at index 15 `out_q_hi` is 0.
- R3: With a the peak index, D = (a-1)*q_lo + a*q_max + (a+1)*q_hi and S = q_lo + q_max + q_hi, the centroid is C = floor(16*D/S) (4 fractional bits), and `out_pos` = floor(C*3500/16) micrometres.
- R4: When S is zero, `out_cent_valid` stays low while `out_sel_valid` is still raised for the slice.
- R5: For a slice accepted with `in_valid` high at a rising edge, `out_sel_valid` is high on the 11th rising edge counting that edge as the first, and not in the cycles before or after.
- R6: Slices presented on consecutive cycles are processed independently, each producing its own result on consecutive output cycles.
- R7: While `rst` is high, both valid outputs are low.
- R8: A cycle with `in_valid` low produces no valid output 11 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slice present on `in_q` |
| in_q | input | 128 | Sixteen 8-bit strip charges, strip i at bits 8*i+7..8*i |
| out_sel_valid | output | 1 | Peak address and charges are valid |
| out_max_addr | output | 4 | Index of the peak strip |
| out_q_lo | output | 8 | Charge of the strip below the peak |
| out_q_max | output | 8 | Peak charge |
| out_q_hi | output | 8 | Charge of the strip above the peak |
| out_cent_valid | output | 1 | Centroid position is valid |
| out_pos | output | 16 | Centroid position in micrometres |

## Verification
The peak position is swept over all sixteen strips against several charge shapes. A lone strip of charge 1 gives an exact integer centroid. Uniform slices and twin peaks test lowest-index tie-breaking. A peak flanked by equal neighbours makes the tie land on the lower neighbour. Random backgrounds at several amplitudes exercise fractional centroids and rounding. All-zero slices separate the address path from the suppressed centroid. Idle cycles scattered among back-to-back slices show that the latency is exact and that no result spills into a neighbouring cycle.

// File: rtl/strip_cent_pkg.sv
package strip_cent_pkg;
    localparam int NSTRIP   = 16;
    localparam int QW       = 8;
    localparam int AW       = $clog2(NSTRIP);
    localparam int FRAC     = 4;
    localparam int PITCH_UM = 3500;
    localparam int SUMW     = QW + 2;
    localparam int DIVW     = SUMW + AW;
    localparam int QB       = AW + FRAC;
    localparam int REMW     = DIVW + FRAC;
    localparam int LATENCY  = QB + 3;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [QW-1:0] q_lo;
        logic [QW-1:0] q_max;
        logic [QW-1:0] q_hi;
    } sel_t;

    function automatic logic [SUMW-1:0] charge_sum(sel_t s);
        return SUMW'(s.q_lo) + SUMW'(s.q_max) + SUMW'(s.q_hi);
    endfunction

    // a*S + q_hi - q_lo is never negative: q_lo is zero when a is zero
    function automatic logic [DIVW-1:0] moment_sum(sel_t s);
        return DIVW'(s.addr) * DIVW'(charge_sum(s)) + DIVW'(s.q_hi) - DIVW'(s.q_lo);
    endfunction
endpackage

// File: rtl/strip_max_sel.sv
module strip_max_sel
    import strip_cent_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [NSTRIP*QW-1:0] in_q,
    output logic                 out_valid,
    output sel_t                 out_sel
);
    logic [QW-1:0] q_arr [NSTRIP];

    for (genvar g = 0; g < NSTRIP; g++) begin : g_split
        assign q_arr[g] = in_q[g*QW +: QW];
    end

    logic [AW-1:0] best_a;
    logic [QW-1:0] best_q;
    sel_t          cand;

    always_comb begin
        best_a = '0;
        best_q = q_arr[0];
        for (int i = 1; i < NSTRIP; i++) begin
            if (q_arr[i] > best_q) begin
                best_q = q_arr[i];
                best_a = AW'(i);
            end
        end
        cand.addr  = best_a;
        cand.q_max = best_q;
        cand.q_lo  = (best_a == '0) ? '0 : q_arr[best_a - AW'(1)];
        cand.q_hi  = (best_a == AW'(NSTRIP-1)) ? '0 : q_arr[best_a + AW'(1)];
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        out_sel <= cand;
    end

    // R1
    max_dominates_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sel.q_max >= out_sel.q_lo && out_sel.q_max >= out_sel.q_hi))
        else $error("peak charge below a neighbour");
endmodule

// File: rtl/strip_sums.sv
module strip_sums
    import strip_cent_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  sel_t            in_sel,
    output logic            out_valid,
    output logic            out_ok,
    output logic [DIVW-1:0] out_num,
    output logic [SUMW-1:0] out_den,
    output sel_t            out_sel
);
    logic [SUMW-1:0] den_n;
    assign den_n = charge_sum(in_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ok    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_ok    <= in_valid && (den_n != '0);
        end
        out_num <= moment_sum(in_sel);
        out_den <= den_n;
        out_sel <= in_sel;
    end

    // R3
    den_covers_peak_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_den >= SUMW'(out_sel.q_max))
        else $error("divisor smaller than peak charge");

    // R4
    ok_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_ok |-> out_valid)
        else $error("divide flagged for an idle cycle");
endmodule

// File: rtl/strip_div_stage.sv
module strip_div_stage
    import strip_cent_pkg::*;
#(
    parameter int BIT = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_ok,
    input  logic [REMW-1:0] in_rem,
    input  logic [SUMW-1:0] in_den,
    input  logic [QB-1:0]   in_quot,
    input  sel_t            in_sel,
    output logic            out_valid,
    output logic            out_ok,
    output logic [REMW-1:0] out_rem,
    output logic [SUMW-1:0] out_den,
    output logic [QB-1:0]   out_quot,
    output sel_t            out_sel
);
    localparam int XW = REMW + 1;

    logic [XW-1:0]   trial;
    logic            fits;
    logic [REMW-1:0] rem_n;
    logic [QB-1:0]   quot_n;

    always_comb begin
        trial       = XW'(in_den) << BIT;
        fits        = XW'(in_rem) >= trial;
        rem_n       = fits ? (in_rem - REMW'(trial)) : in_rem;
        quot_n      = in_quot;
        quot_n[BIT] = fits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ok    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_ok    <= in_ok;
        end
        out_rem  <= rem_n;
        out_den  <= in_den;
        out_quot <= quot_n;
        out_sel  <= in_sel;
    end

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ok) |-> (XW'(out_rem) < (XW'(out_den) << BIT)))
        else $error("restoring remainder out of range");
endmodule

// File: rtl/strip_centroid_top.sv
module strip_centroid_top
    import strip_cent_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [NSTRIP*QW-1:0] in_q,
    output logic                 out_sel_valid,
    output logic [AW-1:0]        out_max_addr,
    output logic [QW-1:0]        out_q_lo,
    output logic [QW-1:0]        out_q_max,
    output logic [QW-1:0]        out_q_hi,
    output logic                 out_cent_valid,
    output logic [15:0]          out_pos
);
    localparam int PW        = QB + $clog2(PITCH_UM + 1);
    localparam int POSW      = $clog2(NSTRIP * PITCH_UM);
    localparam int POS_LIMIT = NSTRIP * PITCH_UM;

    logic s1_valid;
    sel_t s1_sel;

    strip_max_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_q      (in_q),
        .out_valid (s1_valid),
        .out_sel   (s1_sel)
    );

    logic            s2_valid, s2_ok;
    logic [DIVW-1:0] s2_num;
    logic [SUMW-1:0] s2_den;
    sel_t            s2_sel;

    strip_sums u_sums (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_valid),
        .in_sel    (s1_sel),
        .out_valid (s2_valid),
        .out_ok    (s2_ok),
        .out_num   (s2_num),
        .out_den   (s2_den),
        .out_sel   (s2_sel)
    );

    logic            d_valid [QB+1];
    logic            d_ok    [QB+1];
    logic [REMW-1:0] d_rem   [QB+1];
    logic [SUMW-1:0] d_den   [QB+1];
    logic [QB-1:0]   d_quot  [QB+1];
    sel_t            d_sel   [QB+1];

    assign d_valid[0] = s2_valid;
    assign d_ok[0]    = s2_ok;
    assign d_rem[0]   = {s2_num, {FRAC{1'b0}}};
    assign d_den[0]   = s2_den;
    assign d_quot[0]  = '0;
    assign d_sel[0]   = s2_sel;

    for (genvar k = 0; k < QB; k++) begin : g_div
        strip_div_stage #(.BIT(QB-1-k)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (d_valid[k]),
            .in_ok     (d_ok[k]),
            .in_rem    (d_rem[k]),
            .in_den    (d_den[k]),
            .in_quot   (d_quot[k]),
            .in_sel    (d_sel[k]),
            .out_valid (d_valid[k+1]),
            .out_ok    (d_ok[k+1]),
            .out_rem   (d_rem[k+1]),
            .out_den   (d_den[k+1]),
            .out_quot  (d_quot[k+1]),
            .out_sel   (d_sel[k+1])
        );
    end

    logic [PW-1:0] scaled;
    assign scaled = PW'(d_quot[QB]) * PW'(PITCH_UM);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sel_valid  <= 1'b0;
            out_cent_valid <= 1'b0;
        end else begin
            out_sel_valid  <= d_valid[QB];
            out_cent_valid <= d_valid[QB] && d_ok[QB];
        end
        out_max_addr <= d_sel[QB].addr;
        out_q_lo     <= d_sel[QB].q_lo;
        out_q_max    <= d_sel[QB].q_max;
        out_q_hi     <= d_sel[QB].q_hi;
        out_pos      <= POSW'(scaled >> FRAC);
    end

    // R2
    edge_lo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sel_valid && out_max_addr == '0) |-> out_q_lo == '0)
        else $error("missing lower neighbour not zero");

    // R2
    edge_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sel_valid && out_max_addr == AW'(NSTRIP-1)) |-> out_q_hi == '0)
        else $error("missing upper neighbour not zero");

    // R4
    cent_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        out_cent_valid |-> out_sel_valid)
        else $error("centroid valid without selection");

    // R4
    empty_slice_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sel_valid && out_q_max == '0) |-> !out_cent_valid)
        else $error("centroid reported for empty slice");

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_cent_valid |-> 32'(out_pos) < POS_LIMIT)
        else $error("position beyond slice");
endmodule

// File: tb/tb_strip_centroid_top.sv
`timescale 1ns/1ps
module tb_strip_centroid_top;
    localparam int NS    = 16;
    localparam int LAT   = 11;
    localparam int NDRV  = 200;
    localparam int PITCH = 3500;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_q = '0;
    logic         out_sel_valid, out_cent_valid;
    logic [3:0]   out_max_addr;
    logic [7:0]   out_q_lo, out_q_max, out_q_hi;
    logic [15:0]  out_pos;

    always #2.5 clk = ~clk;

    strip_centroid_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_q(in_q),
        .out_sel_valid(out_sel_valid), .out_max_addr(out_max_addr),
        .out_q_lo(out_q_lo), .out_q_max(out_q_max), .out_q_hi(out_q_hi),
        .out_cent_valid(out_cent_valid), .out_pos(out_pos)
    );

    int n_chk = 0;
    int n_fail = 0;

    bit e_v  [NDRV];
    bit e_cv [NDRV];
    int e_a  [NDRV];
    int e_lo [NDRV];
    int e_mx [NDRV];
    int e_hi [NDRV];
    int e_pos[NDRV];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Builds slice k and stores its expected result in entry m
    task automatic make_slice(input int k, input int m);
        int q [NS];
        int a, p, best, lo, hi, d, s, c;
        bit [31:0] st;
        a  = k % NS;
        p  = (k / NS) % 10;
        st = 32'(k) * 32'h9E3779B9 + 32'd1;
        for (int i = 0; i < NS; i++) begin
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            case (p)
                0:       q[i] = 0;
                1:       q[i] = (i == a) ? 1 : 0;
                2:       q[i] = 77;
                3:       q[i] = (i == a || i == NS-1-a) ? 250 : 0;
                4:       q[i] = (i >= a-1 && i <= a+1) ? 255 : int'(st[5:0]);
                default: q[i] = int'(st[7:0]) >> (p - 5);
            endcase
        end
        if (p >= 5) q[a] = 255 - p;
        best = 0;
        for (int i = 1; i < NS; i++) if (q[i] > q[best]) best = i;
        lo = (best == 0) ? 0 : q[best-1];
        hi = (best == NS-1) ? 0 : q[best+1];
        d  = (best-1)*lo + best*q[best] + (best+1)*hi;
        s  = lo + q[best] + hi;
        c  = (s == 0) ? 0 : (16*d) / s;
        e_v[m] = 1'b1; e_a[m] = best; e_lo[m] = lo; e_mx[m] = q[best]; e_hi[m] = hi;
        e_cv[m] = (s != 0);
        e_pos[m] = (c * PITCH) / 16;
        for (int i = 0; i < NS; i++) in_q[8*i +: 8] = 8'(q[i]);
    endtask

    task automatic check_out(input int idx);
        if (idx < 0 || !e_v[idx]) begin
            chk(out_sel_valid == 1'b0, "R8 sel_valid idle", int'(out_sel_valid), 0);
            chk(out_cent_valid == 1'b0, "R8 cent_valid idle", int'(out_cent_valid), 0);
        end else begin
            chk(out_sel_valid == 1'b1, "R5 sel_valid", int'(out_sel_valid), 1);
            chk(int'(out_max_addr) == e_a[idx], "R1 max_addr", int'(out_max_addr), e_a[idx]);
            chk(int'(out_q_max) == e_mx[idx], "R1 q_max", int'(out_q_max), e_mx[idx]);
            chk(int'(out_q_lo) == e_lo[idx], "R2 q_lo", int'(out_q_lo), e_lo[idx]);
            chk(int'(out_q_hi) == e_hi[idx], "R2 q_hi", int'(out_q_hi), e_hi[idx]);
            chk(out_cent_valid == e_cv[idx], "R4 cent_valid", int'(out_cent_valid), int'(e_cv[idx]));
            if (e_cv[idx] && out_cent_valid)
                chk(int'(out_pos) == e_pos[idx], "R3 pos", int'(out_pos), e_pos[idx]);
            // R6: back-to-back slice keeps its own peak
            if (idx > 0 && e_v[idx-1])
                chk(int'(out_q_max) == e_mx[idx], "R6 back-to-back q_max", int'(out_q_max), e_mx[idx]);
        end
    endtask

    initial begin
        int k;
        for (int i = 0; i < NDRV; i++) e_v[i] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7
        chk(out_sel_valid == 1'b0, "R7 sel_valid in reset", int'(out_sel_valid), 0);
        chk(out_cent_valid == 1'b0, "R7 cent_valid in reset", int'(out_cent_valid), 0);
        rst = 1'b0;
        k = 0;
        for (int m = 0; m < NDRV + LAT + 2; m++) begin
            @(negedge clk);
            check_out(m - LAT);
            if (m < NDRV && (m % 7) != 6) begin
                make_slice(k, m);
                in_valid = 1'b1;
                k++;
            end else begin
                in_valid = 1'b0;
                in_q = '0;
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule